// File: doc/BRIEF.md
# Scratchpad-Buffered Memory Command Engine

This block is the byte-level command engine of a single-wire serial memory slave. A link layer beneath it handles bit timing and device addressing. It hands up each received byte, marks every bus reset, and flags a reset that arrived partway through a byte. It also asks for transmit bytes one at a time. The block holds a one-page staging buffer of 32 bytes, a 16-bit target address, a status byte, and a main array of 16 pages of 32 bytes each.

Writes never go straight to the main array. The master first fills the staging buffer and reads it back. It then sends a three-byte echo of the target address and status byte. Only when that echo matches exactly are the staged bytes committed to the addressed page, during a fixed busy period of `COPY_CYCLES` clock cycles. `COPY_CYCLES` must be at least the page size.

The first byte after each bus reset is taken as the command: 0Fh write staging buffer, AAh read staging buffer, 55h commit, F0h read main array. The status byte packs four fields:

| Bits | Contents |
|------|----------|
| 4:0 | Ending offset |
| 5 | Partial-byte flag |
| 6 | Overflow flag |
| 7 | Commit-accepted flag |

`tx_byte` always shows the byte that the next `tx_req` consumes. Outside a transmit phase it reads FFh.

Top module: `scratch_mem_engine`

## Requirements
- R1: After `rst_n` is released, `busy` is 0 and `tx_byte` is FFh. A read of the staging buffer returns a target address of 0000h and a status byte of 00h.
- R2: Command 0Fh takes a low address byte, then a high address byte. The data bytes that follow are stored from offset address[4:0] upward. This command clears all three flags, and the ending offset tracks the offset of the last stored byte.
- R3: A data byte that arrives after offset 31 has been written is discarded and sets the overflow flag (status bit 6). The flag stays set until the next 0Fh command.
- R4: A bus reset flagged as partial during the data phase stores the partial byte at the current offset and sets the ending offset to that offset. It also sets the partial-byte flag (status bit 5), unless offset 31 was already written or overflow is set. In that case the partial-byte flag stays 0 and overflow is set.
- R5: Command AAh returns, in this order: the low address byte, the high address byte, the status byte, and then the staged bytes from the start offset through offset 31. After that it returns FFh.
- R6: Command 55h compares three received bytes with the low address, the high address and the status byte, in that order. On a full match it sets the commit flag (status bit 7). It then copies the staged bytes from the start offset through the ending offset into the main array at page address[8:5] and the same offsets. `busy` stays high for exactly `COPY_CYCLES` cycles, and afterwards `tx_byte` is 00h until a bus reset.
- R7: On any mismatch in the 55h echo, `tx_byte` becomes FFh until a bus reset. The main array and the commit flag are left unchanged.
- R8: A bus reset received while `busy` is high is ignored. The copy runs to completion and the 00h response follows.
- R9: Command F0h takes a low address byte and a high address byte and stores them as the target address. It then returns main-array bytes from that address with auto-increment. Past address 1FFh, or from any address above it, it returns FFh. The status byte is not changed.
- R10: The commit flag is cleared only by a 0Fh command. Read and commit commands leave it set.
- R11: Any other command byte makes the block ignore every byte until the next bus reset, with `tx_byte` held at FFh.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| link_rst | input | 1 | One-cycle pulse for a bus reset seen by the link layer |
| rx_partial | input | 1 | Qualifies `link_rst`: some bits of an unfinished byte were received, and they sit in `rx_byte` |
| rx_valid | input | 1 | One-cycle pulse: `rx_byte` holds a complete received byte |
| rx_byte | input | 8 | Received byte, or the partial byte when `rx_partial` is set |
| tx_req | input | 1 | One-cycle pulse: the link layer has consumed `tx_byte` |
| tx_byte | output | 8 | Byte to be sent on the next request |
| busy | output | 1 | High while a commit copy is in progress |

## Verification
A wrong offset pointer or ending offset appears at the ports as soon as the staging buffer is read back: the status byte is the third transmitted byte, and the echoed data follows it. A fault in the commit path stays hidden until a later read of the main array returns a stale byte at the page offset. So the bench reads the array back after every commit, including after a rejected one, and checks which bytes moved and which stayed. Busy-length and reset-masking faults show within the copy window itself, through `busy` and through the response byte that follows the window.

// File: rtl/smc_pkg.sv
package smc_pkg;

    localparam logic [7:0] OP_STAGE_WR = 8'h0F;
    localparam logic [7:0] OP_STAGE_RD = 8'hAA;
    localparam logic [7:0] OP_COMMIT   = 8'h55;
    localparam logic [7:0] OP_ARRAY_RD = 8'hF0;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_WADR_LO,
        ST_WADR_HI,
        ST_WDATA,
        ST_SRD,
        ST_AUTH,
        ST_COPY,
        ST_ZEROS,
        ST_ONES,
        ST_RADR_LO,
        ST_RADR_HI,
        ST_MRD,
        ST_IDLE
    } smc_state_e;

endpackage

// File: rtl/smc_bytemem.sv
module smc_bytemem #(
    parameter int DEPTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells_q[waddr] <= wdata;
        end
    end

    assign rdata = cells_q[raddr];

endmodule

// File: rtl/smc_ctrl.sv
module smc_ctrl
    import smc_pkg::*;
#(
    parameter int PAGE_BYTES  = 32,
    parameter int PAGES       = 16,
    parameter int COPY_CYCLES = 64,
    localparam int OW        = $clog2(PAGE_BYTES),
    localparam int PW        = $clog2(PAGES),
    localparam int MEM_BYTES = PAGE_BYTES * PAGES,
    localparam int MA_W      = OW + PW,
    localparam int PTR_W     = MA_W + 1,
    localparam int CW        = $clog2(COPY_CYCLES + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            link_rst,
    input  logic            rx_partial,
    input  logic            rx_valid,
    input  logic [7:0]      rx_byte,
    input  logic            tx_req,
    output logic [7:0]      tx_byte,
    output logic            busy,
    output logic            sp_we,
    output logic [OW-1:0]   sp_waddr,
    output logic [7:0]      sp_wdata,
    output logic [OW-1:0]   sp_raddr,
    input  logic [7:0]      sp_rdata,
    output logic            mem_we,
    output logic [MA_W-1:0] mem_waddr,
    output logic [7:0]      mem_wdata,
    output logic [MA_W-1:0] mem_raddr,
    input  logic [7:0]      mem_rdata
);

    typedef struct packed {
        smc_state_e       st;
        logic [15:0]      ta;
        logic [OW-1:0]    e;
        logic             pf;
        logic             of;
        logic             aa;
        logic [OW-1:0]    off;
        logic             end_f;
        logic [1:0]       idx;
        logic [PTR_W-1:0] ptr;
        logic [CW-1:0]    cnt;
    } ctrl_s;

    localparam logic [OW-1:0]    LAST_OFF = OW'(PAGE_BYTES - 1);
    localparam logic [PTR_W-1:0] PTR_END  = PTR_W'(MEM_BYTES);

    ctrl_s q, d;
    logic [7:0]  es;
    logic [7:0]  auth_ref;
    logic [15:0] new_ta;

    assign es       = {q.aa, q.of, q.pf, 5'(q.e)};
    assign new_ta   = {rx_byte, q.ta[7:0]};
    assign auth_ref = (q.idx == 2'd0) ? q.ta[7:0] :
                      (q.idx == 2'd1) ? q.ta[15:8] : es;

    always_comb begin
        d        = q;
        sp_we    = 1'b0;
        sp_wdata = rx_byte;
        mem_we   = 1'b0;
        if (link_rst && q.st != ST_COPY) begin
            if (q.st == ST_WDATA && rx_partial) begin
                if (!q.end_f && !q.of) begin
                    sp_we = 1'b1;
                    d.e   = q.off;
                    d.pf  = 1'b1;
                end else begin
                    d.of  = 1'b1;
                end
            end
            d.st = ST_CMD;
        end else begin
            unique case (q.st)
                ST_CMD: if (rx_valid) begin
                    unique case (rx_byte)
                        OP_STAGE_WR: begin
                            d.st = ST_WADR_LO;
                            d.pf = 1'b0;
                            d.of = 1'b0;
                            d.aa = 1'b0;
                        end
                        OP_STAGE_RD: begin
                            d.st    = ST_SRD;
                            d.idx   = 2'd0;
                            d.off   = q.ta[OW-1:0];
                            d.end_f = 1'b0;
                        end
                        OP_COMMIT: begin
                            d.st  = ST_AUTH;
                            d.idx = 2'd0;
                        end
                        OP_ARRAY_RD: d.st = ST_RADR_LO;
                        default:     d.st = ST_IDLE;
                    endcase
                end
                ST_WADR_LO: if (rx_valid) begin
                    d.ta[7:0] = rx_byte;
                    d.st      = ST_WADR_HI;
                end
                ST_WADR_HI: if (rx_valid) begin
                    d.ta[15:8] = rx_byte;
                    d.off      = q.ta[OW-1:0];
                    d.e        = q.ta[OW-1:0];
                    d.end_f    = 1'b0;
                    d.st       = ST_WDATA;
                end
                ST_WDATA: if (rx_valid) begin
                    if (q.end_f) begin
                        d.of = 1'b1;
                    end else begin
                        sp_we = 1'b1;
                        d.e   = q.off;
                        if (q.off == LAST_OFF) d.end_f = 1'b1;
                        else                   d.off   = q.off + 1'b1;
                    end
                end
                ST_SRD: if (tx_req) begin
                    if (q.idx != 2'd3) begin
                        d.idx = q.idx + 2'd1;
                    end else if (!q.end_f) begin
                        if (q.off == LAST_OFF) d.end_f = 1'b1;
                        else                   d.off   = q.off + 1'b1;
                    end
                end
                ST_AUTH: if (rx_valid) begin
                    if (rx_byte != auth_ref) begin
                        d.st = ST_ONES;
                    end else if (q.idx == 2'd2) begin
                        d.aa    = 1'b1;
                        d.off   = q.ta[OW-1:0];
                        d.end_f = 1'b0;
                        d.cnt   = CW'(COPY_CYCLES);
                        d.st    = ST_COPY;
                    end else begin
                        d.idx = q.idx + 2'd1;
                    end
                end
                ST_COPY: begin
                    if (!q.end_f) begin
                        mem_we = 1'b1;
                        if (q.off == q.e) d.end_f = 1'b1;
                        else              d.off   = q.off + 1'b1;
                    end
                    d.cnt = q.cnt - 1'b1;
                    if (q.cnt == CW'(1)) d.st = ST_ZEROS;
                end
                ST_RADR_LO: if (rx_valid) begin
                    d.ta[7:0] = rx_byte;
                    d.st      = ST_RADR_HI;
                end
                ST_RADR_HI: if (rx_valid) begin
                    d.ta[15:8] = rx_byte;
                    d.ptr      = (new_ta >= 16'(MEM_BYTES)) ? PTR_END : PTR_W'(new_ta);
                    d.st       = ST_MRD;
                end
                ST_MRD: if (tx_req && q.ptr != PTR_END) begin
                    d.ptr = q.ptr + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_CMD;
        end else begin
            q <= d;
        end
    end

    assign sp_waddr  = q.off;
    assign sp_raddr  = q.off;
    assign mem_waddr = {q.ta[OW+PW-1:OW], q.off};
    assign mem_wdata = sp_rdata;
    assign mem_raddr = q.ptr[MA_W-1:0];
    assign busy      = (q.st == ST_COPY);

    always_comb begin
        unique case (q.st)
            ST_SRD: begin
                unique case (q.idx)
                    2'd0:    tx_byte = q.ta[7:0];
                    2'd1:    tx_byte = q.ta[15:8];
                    2'd2:    tx_byte = es;
                    default: tx_byte = q.end_f ? 8'hFF : sp_rdata;
                endcase
            end
            ST_MRD:   tx_byte = (q.ptr == PTR_END) ? 8'hFF : mem_rdata;
            ST_ZEROS: tx_byte = 8'h00;
            default:  tx_byte = 8'hFF;
        endcase
    end

    // Checker state: consecutive cycles with busy high.
    logic [31:0] busy_len_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    busy_len_q <= '0;
        else if (busy) busy_len_q <= busy_len_q + 32'd1;
        else           busy_len_q <= '0;
    end

    assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (q.of && !(q.st == ST_CMD && rx_valid && rx_byte == OP_STAGE_WR)) |=> q.of);

    assert_partial_excludes_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.pf) |-> !q.of);

    assert_copy_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> busy_len_q == 32'(COPY_CYCLES));

    assert_zeros_after_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> tx_byte == 8'h00);

    assert_copy_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (q.off <= q.e && q.off >= q.ta[OW-1:0]));

    assert_reset_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && link_rst) |=> (busy || tx_byte == 8'h00));

    assert_aa_cleared_by_write_only_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.aa) |-> $past(q.st == ST_CMD && rx_valid && rx_byte == OP_STAGE_WR && !link_rst));

endmodule

// File: rtl/scratch_mem_engine.sv
module scratch_mem_engine #(
    parameter int PAGE_BYTES  = 32,
    parameter int PAGES       = 16,
    parameter int COPY_CYCLES = 64,
    localparam int OW        = $clog2(PAGE_BYTES),
    localparam int MEM_BYTES = PAGE_BYTES * PAGES,
    localparam int MA_W      = $clog2(MEM_BYTES)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       link_rst,
    input  logic       rx_partial,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    output logic [7:0] tx_byte,
    output logic       busy
);

    logic            sp_we, mem_we;
    logic [OW-1:0]   sp_waddr, sp_raddr;
    logic [7:0]      sp_wdata, sp_rdata, mem_wdata, mem_rdata;
    logic [MA_W-1:0] mem_waddr, mem_raddr;

    smc_ctrl #(
        .PAGE_BYTES (PAGE_BYTES),
        .PAGES      (PAGES),
        .COPY_CYCLES(COPY_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_rst  (link_rst),
        .rx_partial(rx_partial),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_req    (tx_req),
        .tx_byte   (tx_byte),
        .busy      (busy),
        .sp_we     (sp_we),
        .sp_waddr  (sp_waddr),
        .sp_wdata  (sp_wdata),
        .sp_raddr  (sp_raddr),
        .sp_rdata  (sp_rdata),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_raddr (mem_raddr),
        .mem_rdata (mem_rdata)
    );

    smc_bytemem #(.DEPTH(PAGE_BYTES)) u_stage (
        .clk  (clk),
        .we   (sp_we),
        .waddr(sp_waddr),
        .wdata(sp_wdata),
        .raddr(sp_raddr),
        .rdata(sp_rdata)
    );

    smc_bytemem #(.DEPTH(MEM_BYTES)) u_array (
        .clk  (clk),
        .we   (mem_we),
        .waddr(mem_waddr),
        .wdata(mem_wdata),
        .raddr(mem_raddr),
        .rdata(mem_rdata)
    );

endmodule

// File: tb/scratch_mem_engine_tb.sv
module scratch_mem_engine_tb_top;

    localparam int COPY_CYCLES = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       link_rst = 1'b0;
    logic       rx_partial = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic [7:0] tx_byte;
    logic       busy;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    scratch_mem_engine #(.COPY_CYCLES(COPY_CYCLES)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .link_rst  (link_rst),
        .rx_partial(rx_partial),
        .rx_valid  (rx_valid),
        .rx_byte   (rx_byte),
        .tx_req    (tx_req),
        .tx_byte   (tx_byte),
        .busy      (busy)
    );

    // Vector: [13:10] requirement number, [9:8] kind, [7:0] byte.
    // Kinds: 0 bus reset, 1 receive byte, 2 expect transmit byte, 3 wait for busy low.
    localparam int NV = 32;
    localparam logic [13:0] VEC [NV] = '{
        {4'd0, 2'd0, 8'h00},                                              // reset
        {4'd0, 2'd1, 8'h0F}, {4'd0, 2'd1, 8'h26}, {4'd0, 2'd1, 8'h00},  // R2 write, TA=0026h
        {4'd0, 2'd1, 8'hA1}, {4'd0, 2'd1, 8'hB2},
        {4'd0, 2'd0, 8'h00},
        {4'd0, 2'd1, 8'hAA},                                              // R5 readback
        {4'd5, 2'd2, 8'h26}, {4'd5, 2'd2, 8'h00},
        {4'd2, 2'd2, 8'h07}, {4'd2, 2'd2, 8'hA1}, {4'd2, 2'd2, 8'hB2},  // R2 E=7, data
        {4'd0, 2'd0, 8'h00},
        {4'd0, 2'd1, 8'h55}, {4'd0, 2'd1, 8'h26}, {4'd0, 2'd1, 8'h00},  // R6 commit
        {4'd0, 2'd1, 8'h07},
        {4'd0, 2'd3, 8'h00},
        {4'd6, 2'd2, 8'h00}, {4'd6, 2'd2, 8'h00},
        {4'd0, 2'd0, 8'h00},
        {4'd0, 2'd1, 8'hF0}, {4'd0, 2'd1, 8'h26}, {4'd0, 2'd1, 8'h00},  // R9 array read
        {4'd9, 2'd2, 8'hA1}, {4'd9, 2'd2, 8'hB2},
        {4'd0, 2'd0, 8'h00},
        {4'd0, 2'd1, 8'hAA},
        {4'd9, 2'd2, 8'h26}, {4'd9, 2'd2, 8'h00},
        {4'd10, 2'd2, 8'h87}                                              // R10 AA kept, E unchanged
    };

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_rst(input logic part, input logic [7:0] pb);
        @(negedge clk);
        link_rst = 1'b1; rx_partial = part; rx_byte = pb;
        @(negedge clk);
        link_rst = 1'b0; rx_partial = 1'b0;
    endtask

    task automatic rx(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic tx(input logic [7:0] exp, input string tag);
        @(negedge clk);
        chk(tx_byte, exp, tag);
        tx_req = 1'b1;
        @(negedge clk);
        tx_req = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk({7'd0, busy}, 8'h00, "R1 busy");
        chk(tx_byte, 8'hFF, "R1 idle tx");
        rx(8'hAA);
        tx(8'h00, "R1 TA lo"); tx(8'h00, "R1 TA hi"); tx(8'h00, "R1 status");

        // Table walk
        for (int i = 0; i < NV; i++) begin
            unique case (VEC[i][9:8])
                2'd0: bus_rst(1'b0, 8'h00);
                2'd1: rx(VEC[i][7:0]);
                2'd2: tx(VEC[i][7:0], $sformatf("R%0d vector %0d", VEC[i][13:10], i));
                default: wait_idle();
            endcase
        end

        // R3 overflow: start 30, three data bytes; R4 partial after overflow leaves PF clear
        bus_rst(1'b0, 8'h00);
        rx(8'h0F); rx(8'h1E); rx(8'h01); rx(8'h11); rx(8'h22); rx(8'h33);
        bus_rst(1'b1, 8'h05);
        rx(8'hAA);
        tx(8'h1E, "R5 TA lo"); tx(8'h01, "R5 TA hi");
        tx(8'h5F, "R3 status OF set, R4 PF clear");
        tx(8'h11, "R3 data30"); tx(8'h22, "R3 data31");
        tx(8'hFF, "R5 ones after end"); tx(8'hFF, "R5 ones again");

        // R4 partial byte, then commit with whole-byte copy and busy length
        bus_rst(1'b0, 8'h00);
        rx(8'h0F); rx(8'h40); rx(8'h00); rx(8'h5A);
        bus_rst(1'b1, 8'h03);
        rx(8'hAA);
        tx(8'h40, "R4 TA lo"); tx(8'h00, "R4 TA hi");
        tx(8'h21, "R4 status PF E=1"); tx(8'h5A, "R4 data0"); tx(8'h03, "R4 partial data1");
        bus_rst(1'b0, 8'h00);
        rx(8'h55); rx(8'h40); rx(8'h00); rx(8'h21);
        n = 0;
        while (busy && n < 10000) begin n++; @(negedge clk); end
        chk(8'(n), 8'(COPY_CYCLES), "R6 busy length");
        tx(8'h00, "R6 zeros after copy");
        bus_rst(1'b0, 8'h00);
        rx(8'hF0); rx(8'h40); rx(8'h00);
        tx(8'h5A, "R6 copied byte 40h"); tx(8'h03, "R6 copied partial byte 41h");

        // R7 mismatch leaves array alone; R10 write clears AA
        bus_rst(1'b0, 8'h00);
        rx(8'h0F); rx(8'h40); rx(8'h00); rx(8'h77);
        bus_rst(1'b0, 8'h00);
        rx(8'hAA);
        tx(8'h40, "R10 TA lo"); tx(8'h00, "R10 TA hi"); tx(8'h00, "R10 AA cleared by write");
        bus_rst(1'b0, 8'h00);
        rx(8'h55); rx(8'h40); rx(8'h00); rx(8'h01);
        chk({7'd0, busy}, 8'h00, "R7 no busy on mismatch");
        tx(8'hFF, "R7 ones on mismatch");
        bus_rst(1'b0, 8'h00);
        rx(8'hF0); rx(8'h40); rx(8'h00);
        tx(8'h5A, "R7 array unchanged");

        // R8 bus reset during copy is ignored
        bus_rst(1'b0, 8'h00);
        rx(8'h55); rx(8'h40); rx(8'h00); rx(8'h00);
        chk({7'd0, busy}, 8'h01, "R8 busy started");
        bus_rst(1'b0, 8'h00);
        chk({7'd0, busy}, 8'h01, "R8 busy after reset pulse");
        wait_idle();
        tx(8'h00, "R8 zeros still sent");
        bus_rst(1'b0, 8'h00);
        rx(8'hF0); rx(8'h40); rx(8'h00);
        tx(8'h77, "R6 single byte copied"); tx(8'h03, "R6 neighbour kept");

        // R9 end of array
        bus_rst(1'b0, 8'h00);
        rx(8'h0F); rx(8'hFF); rx(8'h01); rx(8'hCC);
        bus_rst(1'b0, 8'h00);
        rx(8'h55); rx(8'hFF); rx(8'h01); rx(8'h1F);
        wait_idle();
        bus_rst(1'b0, 8'h00);
        rx(8'hF0); rx(8'hFF); rx(8'h01);
        tx(8'hCC, "R9 last byte"); tx(8'hFF, "R9 ones past end"); tx(8'hFF, "R9 ones stay");
        bus_rst(1'b0, 8'h00);
        rx(8'hF0); rx(8'h00); rx(8'h02);
        tx(8'hFF, "R9 address above array");

        // R11 unknown command
        bus_rst(1'b0, 8'h00);
        rx(8'h3C); rx(8'hAA);
        tx(8'hFF, "R11 ignored byte"); tx(8'hFF, "R11 ones");
        bus_rst(1'b0, 8'h00);
        rx(8'hAA);
        tx(8'h00, "R11 recovers after reset");

        report();
        $finish;
    end

endmodule